// File: doc/BRIEF.md
# Segment-Aware Sample Capture Controller

This block sits behind a trigger detector and in front of a host transport. It writes one probed data word into an on-chip sample memory on every clock while an acquisition runs, and decides which of those words survive relative to a one-cycle trigger strobe. The memory is split into one, two or four equal segments, and each segment holds the window around one trigger event. A single-segment run is the circular capture. A segmented run moves on to the next segment by itself after each segment closes, and finishes when the last segment closes. A third mode keeps writing round the whole memory and pays no attention to the trigger until the host stops it.

The trigger position sets how many samples are stored from the trigger onward. The trigger sample itself counts as the first of them. The rest of the segment holds the samples that came before. Each segment records where its trigger landed and where its oldest sample sits. The readout port takes a segment number and an index, with index 0 the oldest sample, and returns that sample one clock later. Two combinational outputs give the trigger's index in the window and the number of valid samples. A channel mask zeroes the data lanes that are not captured.

States: `ST_IDLE` (nothing running), `ST_WAIT` (writing round the segment, waiting for a trigger), `ST_POST` (filling the samples after the trigger), `ST_DONE` (capture held for readout). The transitions are: arm (IDLE or DONE to WAIT); trigger hit (WAIT to POST); segment close (WAIT or POST to WAIT when segments remain, to DONE on the last segment); stop (halt in WAIT/POST of a triggered mode to IDLE, halt in free-run mode to DONE).

Top module: `cap_capture_ctrl`

## Requirements
- R1: After reset the status state is IDLE (code 0) and the status segment number is 0.
- R2: An arm pulse in IDLE or DONE moves the state to WAIT (code 1) on the next clock. One sample is written on every clock spent in WAIT or POST (code 2), and none is written in any other state.
- R3: The mode is set by `mode`: 0 is circular, 1 is segmented, 2 is free-run. The trigger position is set by `trig_pos`: 0 is pre, 1 is center, 2 is post. For a segment length L, the number of samples stored from the trigger onward, the trigger sample included, is P = L - L/8 for pre, L/2 for center and L/8 for post. The state reaches DONE (code 3) exactly P-1 clocks after the trigger clock, and the reported trigger index is L-P.
- R4: Readout index i of a segment returns, one clock after `rd_seg`/`rd_idx` are applied, the i-th oldest sample of that segment's window. The newest stored sample is at index L-1.
- R5: The valid count is min(samples written in the segment, L). A trigger that comes before the pre-trigger part has filled is still accepted, and the valid count then reports how many samples really exist, these being the last ones in the window.
- R6: In segmented mode, `seg_log` picks 2^seg_log segments, each DEPTH/2^seg_log long. After each segment closes, the status segment number goes up by one and the state goes back to WAIT. The state becomes DONE when the last segment closes.
- R7: A data lane whose `chan_en` bit is 0 is stored and read back as 0.
- R8: In free-run mode the trigger has no effect and the state stays WAIT. A halt pulse then gives DONE with the newest sample at index L-1, a valid count of min(writes, L) and a trigger index of 0.
- R9: A halt pulse in WAIT or POST of circular or segmented mode returns the state to IDLE.
- R10: A trigger in IDLE or DONE is ignored. DONE is held until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start an acquisition (pulse) |
| halt | input | 1 | Stop the acquisition (pulse) |
| mode | input | 2 | 0 circular, 1 segmented, 2 free-run; latched at arm |
| trig_pos | input | 2 | 0 pre, 1 center, 2 post; latched at arm |
| seg_log | input | SL_W | log2 of the segment count in segmented mode; latched at arm |
| din | input | DATA_W | Probed data word |
| trig | input | 1 | Trigger strobe |
| chan_en | input | DATA_W | Per-lane capture enable |
| stat_state | output | 2 | 0 IDLE, 1 WAIT, 2 POST, 3 DONE |
| stat_seg | output | SEG_W | Segment currently being filled |
| rd_seg | input | SEG_W | Segment to read |
| rd_idx | input | ADDR_W | Oldest-first index within the segment |
| rd_data | output | DATA_W | Sample at that index, one clock later |
| rd_valid_cnt | output | ADDR_W+1 | Valid samples in the selected segment |
| rd_trig_idx | output | ADDR_W | Index of the trigger sample in the selected segment |

## Verification
The bench triggers before the pre-trigger part has filled. A controller that assumed a full window would report a valid count of L and put stale samples at the front. It checks the exact clock on which DONE appears for the pre and post positions, because an off-by-one in the post-trigger counter shifts every stored window by one sample. It reads the oldest, trigger and newest indices after the write pointer has wrapped, where a reordering error would show. It also runs four segments back to back to catch a segment base or counter that does not advance. Finally it sends triggers in free-run mode, in IDLE and in DONE, where a design that reacted to them would leave its state.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_state_e;

    localparam logic [1:0] MD_CIRC = 2'd0;
    localparam logic [1:0] MD_SEG  = 2'd1;
    localparam logic [1:0] MD_FREE = 2'd2;

    localparam logic [1:0] POS_PRE = 2'd0;
    localparam logic [1:0] POS_MID = 2'd1;
    localparam logic [1:0] POS_END = 2'd2;
endpackage

// File: rtl/cap_fsm.sv
module cap_fsm
    import cap_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int SEGLOG_MAX = 2,
    parameter int ADDR_W     = $clog2(DEPTH),
    parameter int CW         = ADDR_W + 1,
    parameter int SEG_W      = (SEGLOG_MAX < 1) ? 1 : SEGLOG_MAX,
    parameter int SL_W       = $clog2(SEGLOG_MAX + 1) < 1 ? 1 : $clog2(SEGLOG_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              halt,
    input  logic [1:0]        mode,
    input  logic [1:0]        trig_pos,
    input  logic [SL_W-1:0]   seg_log,
    input  logic              trig,
    output cap_state_e        state,
    output logic [SEG_W-1:0]  cur_seg,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CW-1:0]     seg_len,
    output logic [ADDR_W-1:0] seg_mask,
    output logic              rec_we,
    output logic [SEG_W-1:0]  rec_seg,
    output logic [ADDR_W-1:0] rec_oldest,
    output logic [ADDR_W-1:0] rec_trig,
    output logic [CW-1:0]     rec_valid
);
    cap_state_e        state_nx;
    logic [1:0]        mode_q, pos_q;
    logic [SL_W-1:0]   slog_q, slog_in;
    logic [ADDR_W-1:0] wptr, wptr_nx, trig_off;
    logic [CW-1:0]     fill, fill_nx, post_cnt, post_len;
    logic [SEG_W-1:0]  last_seg;
    logic              running, trig_hit, close, free_stop, is_last;

    always_comb begin
        if (mode != MD_SEG)
            slog_in = '0;
        else if (int'(seg_log) > SEGLOG_MAX)
            slog_in = SL_W'(SEGLOG_MAX);
        else
            slog_in = seg_log;
    end

    always_comb begin
        seg_len  = CW'(DEPTH) >> slog_q;
        seg_mask = ADDR_W'(seg_len - CW'(1));
        last_seg = SEG_W'((CW'(1) << slog_q) - CW'(1));
        unique case (pos_q)
            POS_PRE: post_len = seg_len - (seg_len >> 3);
            POS_MID: post_len = seg_len >> 1;
            default: post_len = seg_len >> 3;
        endcase
    end

    // next state and datapath strobes
    always_comb begin
        running   = (state == ST_WAIT) || (state == ST_POST);
        wr_en     = running && !halt;
        wptr_nx   = (wptr + ADDR_W'(1)) & seg_mask;
        fill_nx   = (fill == seg_len) ? fill : fill + CW'(1);
        is_last   = (cur_seg == last_seg);
        trig_hit  = wr_en && (state == ST_WAIT) && trig && (mode_q != MD_FREE);
        close     = (trig_hit && post_len == CW'(1))
                  || (wr_en && state == ST_POST && post_cnt + CW'(1) == post_len);
        free_stop = (state == ST_WAIT) && halt && (mode_q == MD_FREE);
        wr_addr   = ADDR_W'(CW'(cur_seg) * seg_len) + wptr;

        rec_we     = close || free_stop;
        rec_seg    = cur_seg;
        rec_oldest = free_stop ? wptr : wptr_nx;
        rec_trig   = free_stop ? wptr : (trig_hit ? wptr : trig_off);
        rec_valid  = free_stop ? fill : fill_nx;

        state_nx = state;
        unique case (state)
            ST_IDLE: if (arm) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (halt)
                    state_nx = (mode_q == MD_FREE) ? ST_DONE : ST_IDLE;
                else if (close)
                    state_nx = is_last ? ST_DONE : ST_WAIT;
                else if (trig_hit)
                    state_nx = ST_POST;
            end
            ST_POST: begin
                if (halt)
                    state_nx = ST_IDLE;
                else if (close)
                    state_nx = is_last ? ST_DONE : ST_WAIT;
            end
            ST_DONE: if (arm) state_nx = ST_WAIT;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode_q   <= MD_CIRC;
            pos_q    <= POS_PRE;
            slog_q   <= '0;
            cur_seg  <= '0;
            wptr     <= '0;
            fill     <= '0;
            post_cnt <= '0;
            trig_off <= '0;
        end else begin
            state <= state_nx;
            if ((state == ST_IDLE || state == ST_DONE) && arm) begin
                mode_q   <= mode;
                pos_q    <= trig_pos;
                slog_q   <= slog_in;
                cur_seg  <= '0;
                wptr     <= '0;
                fill     <= '0;
                post_cnt <= '0;
            end else if (close && !is_last) begin
                cur_seg  <= cur_seg + SEG_W'(1);
                wptr     <= '0;
                fill     <= '0;
                post_cnt <= '0;
            end else if (wr_en) begin
                wptr <= wptr_nx;
                fill <= fill_nx;
                if (trig_hit) begin
                    trig_off <= wptr;
                    post_cnt <= CW'(1);
                end else if (state == ST_POST) begin
                    post_cnt <= post_cnt + CW'(1);
                end
            end
        end
    end

    p_write_only_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_WAIT || state == ST_POST));
    p_post_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST) |-> (post_cnt < post_len));
    p_free_no_post_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_FREE && state != ST_IDLE) |-> (state != ST_POST));
    p_seg_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_seg <= last_seg);
    p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !arm) |=> (state == ST_DONE));
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !arm) |=> (state == ST_IDLE));
endmodule

// File: rtl/cap_seg_table.sv
module cap_seg_table #(
    parameter int SEGLOG_MAX = 2,
    parameter int ADDR_W     = 6,
    parameter int CW         = ADDR_W + 1,
    parameter int SEG_W      = (SEGLOG_MAX < 1) ? 1 : SEGLOG_MAX,
    parameter int NSEG       = 1 << SEGLOG_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_we,
    input  logic [SEG_W-1:0]  rec_seg,
    input  logic [ADDR_W-1:0] rec_oldest,
    input  logic [ADDR_W-1:0] rec_trig,
    input  logic [CW-1:0]     rec_valid,
    input  logic [CW-1:0]     seg_len,
    input  logic [ADDR_W-1:0] seg_mask,
    input  logic [SEG_W-1:0]  rd_seg,
    output logic [ADDR_W-1:0] rd_oldest,
    output logic [ADDR_W-1:0] rd_trig_idx,
    output logic [CW-1:0]     rd_valid
);
    logic [ADDR_W-1:0] oldest_q [NSEG];
    logic [ADDR_W-1:0] trig_q   [NSEG];
    logic [CW-1:0]     valid_q  [NSEG];

    for (genvar s = 0; s < NSEG; s++) begin : g_rec
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                oldest_q[s] <= '0;
                trig_q[s]   <= '0;
                valid_q[s]  <= '0;
            end else if (rec_we && rec_seg == SEG_W'(s)) begin
                oldest_q[s] <= rec_oldest;
                trig_q[s]   <= rec_trig;
                valid_q[s]  <= rec_valid;
            end
        end
    end

    always_comb begin
        rd_oldest   = oldest_q[rd_seg];
        rd_trig_idx = (trig_q[rd_seg] - oldest_q[rd_seg]) & seg_mask;
        rd_valid    = valid_q[rd_seg];
    end

    p_valid_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_we |-> (rec_valid <= seg_len));
endmodule

// File: rtl/cap_sample_ram.sv
module cap_sample_ram #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/cap_capture_ctrl.sv
module cap_capture_ctrl
    import cap_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 64,
    parameter int SEGLOG_MAX = 2,
    parameter int ADDR_W     = $clog2(DEPTH),
    parameter int SEG_W      = (SEGLOG_MAX < 1) ? 1 : SEGLOG_MAX,
    parameter int SL_W       = $clog2(SEGLOG_MAX + 1) < 1 ? 1 : $clog2(SEGLOG_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              halt,
    input  logic [1:0]        mode,
    input  logic [1:0]        trig_pos,
    input  logic [SL_W-1:0]   seg_log,
    input  logic [DATA_W-1:0] din,
    input  logic              trig,
    input  logic [DATA_W-1:0] chan_en,
    output logic [1:0]        stat_state,
    output logic [SEG_W-1:0]  stat_seg,
    input  logic [SEG_W-1:0]  rd_seg,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W:0]   rd_valid_cnt,
    output logic [ADDR_W-1:0] rd_trig_idx
);
    localparam int CW = ADDR_W + 1;

    cap_state_e        state;
    logic              wr_en, rec_we;
    logic [ADDR_W-1:0] wr_addr, seg_mask, rec_oldest, rec_trig, rd_oldest, rd_addr;
    logic [CW-1:0]     seg_len, rec_valid;
    logic [SEG_W-1:0]  rec_seg;

    cap_fsm #(.DEPTH(DEPTH), .SEGLOG_MAX(SEGLOG_MAX), .ADDR_W(ADDR_W), .CW(CW),
              .SEG_W(SEG_W), .SL_W(SL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(arm), .halt(halt), .mode(mode),
        .trig_pos(trig_pos), .seg_log(seg_log), .trig(trig),
        .state(state), .cur_seg(stat_seg), .wr_en(wr_en), .wr_addr(wr_addr),
        .seg_len(seg_len), .seg_mask(seg_mask), .rec_we(rec_we), .rec_seg(rec_seg),
        .rec_oldest(rec_oldest), .rec_trig(rec_trig), .rec_valid(rec_valid)
    );

    cap_seg_table #(.SEGLOG_MAX(SEGLOG_MAX), .ADDR_W(ADDR_W), .CW(CW), .SEG_W(SEG_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .rec_we(rec_we), .rec_seg(rec_seg),
        .rec_oldest(rec_oldest), .rec_trig(rec_trig), .rec_valid(rec_valid),
        .seg_len(seg_len), .seg_mask(seg_mask), .rd_seg(rd_seg),
        .rd_oldest(rd_oldest), .rd_trig_idx(rd_trig_idx), .rd_valid(rd_valid_cnt)
    );

    assign rd_addr    = ADDR_W'(CW'(rd_seg) * seg_len) + ((rd_oldest + rd_idx) & seg_mask);
    assign stat_state = state;

    cap_sample_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(din & chan_en),
        .raddr(rd_addr), .rdata(rd_data)
    );

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (stat_state == 2'd0 || !rst_n));
endmodule

// File: tb/cap_capture_ctrl_test.sv
module cap_capture_ctrl_test;
    localparam int DW = 8, DEPTH = 64, AW = 6;

    logic clk = 0, rst_n = 0, arm = 0, halt = 0, trig = 0;
    logic [1:0] mode = 0, trig_pos = 0, seg_log = 0;
    logic [DW-1:0] din, chan_en = '1;
    logic [1:0] stat_state, rd_seg = 0, stat_seg;
    logic [AW-1:0] rd_idx = 0, rd_trig_idx;
    logic [DW-1:0] rd_data;
    logic [AW:0] rd_valid_cnt;
    logic [7:0] cyc = 0;
    int checks = 0, failures = 0, ticks = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 8'd1;
    assign din = cyc;

    cap_capture_ctrl uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .halt(halt), .mode(mode),
        .trig_pos(trig_pos), .seg_log(seg_log), .din(din), .trig(trig),
        .chan_en(chan_en), .stat_state(stat_state), .stat_seg(stat_seg),
        .rd_seg(rd_seg), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_valid_cnt(rd_valid_cnt), .rd_trig_idx(rd_trig_idx)
    );

    always @(posedge clk) begin
        ticks <= ticks + 1;
        if (ticks > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_arm(input logic [1:0] m, input logic [1:0] p, input logic [1:0] sl);
        @(negedge clk);
        mode = m; trig_pos = p; seg_log = sl; arm = 1;
        @(negedge clk);
        arm = 0;
    endtask

    task automatic fire(output logic [7:0] t);
        t = din; trig = 1;
        @(negedge clk);
        trig = 0;
    endtask

    task automatic stop_run(output logic [7:0] v);
        v = din; halt = 1;
        @(negedge clk);
        halt = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (stat_state != 2'd3 && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic rd(input int s, input int i, output logic [7:0] d);
        rd_seg = 2'(s); rd_idx = AW'(i);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic t_reset();
        check("R1 state", int'(stat_state), 0);
        check("R1 seg", int'(stat_seg), 0);
    endtask

    task automatic t_circ_pre();
        logic [7:0] t, d; int n;
        do_arm(2'd0, 2'd0, 2'd0);
        check("R2 arm to WAIT", int'(stat_state), 1);
        idle(20);
        fire(t);
        check("R3 POST after trigger", int'(stat_state), 2);
        wait_done(n);
        check("R3 pre post-count clocks", n, 55);
        rd(0, 8, d);
        check("R3 pre trig idx", int'(rd_trig_idx), 8);
        check("R5 full valid", int'(rd_valid_cnt), 64);
        check("R4 trigger sample", int'(d), int'(t));
        rd(0, 0, d);
        check("R4 oldest", int'(d), int'(8'(t - 8'd8)));
        rd(0, 63, d);
        check("R4 newest", int'(d), int'(8'(t + 8'd55)));
        rd(0, 30, d);
        check("R2 one write per clock", int'(d), int'(8'(t + 8'd22)));
    endtask

    task automatic t_circ_early();
        logic [7:0] t, d; int n;
        do_arm(2'd0, 2'd1, 2'd0);
        idle(5);
        fire(t);
        wait_done(n);
        check("R3 center clocks", n, 31);
        check("R5 early valid", int'(rd_valid_cnt), 37);
        check("R3 center trig idx", int'(rd_trig_idx), 32);
        rd(0, 27, d);
        check("R5 first real sample", int'(d), int'(8'(t - 8'd5)));
    endtask

    task automatic t_circ_post();
        logic [7:0] t, d; int n;
        do_arm(2'd0, 2'd2, 2'd0);
        idle(70);
        fire(t);
        wait_done(n);
        check("R3 post clocks", n, 7);
        check("R3 post trig idx", int'(rd_trig_idx), 56);
        rd(0, 63, d);
        check("R4 post newest", int'(d), int'(8'(t + 8'd7)));
        fire(t);
        check("R10 trig in DONE ignored", int'(stat_state), 3);
        idle(3);
        check("R10 DONE held", int'(stat_state), 3);
    endtask

    task automatic t_segmented();
        logic [7:0] ts [4]; logic [7:0] d; int n;
        do_arm(2'd1, 2'd1, 2'd2);
        for (int s = 0; s < 4; s++) begin
            check("R6 seg number", int'(stat_seg), s);
            idle(10);
            fire(ts[s]);
            idle(7);
            if (s < 3) check("R6 back to WAIT", int'(stat_state), 1);
        end
        wait_done(n);
        check("R6 DONE after last", int'(stat_state), 3);
        for (int s = 0; s < 4; s++) begin
            rd(s, 8, d);
            check("R6 seg trig idx", int'(rd_trig_idx), 8);
            check("R6 seg valid", int'(rd_valid_cnt), 16);
            check("R6 seg trig sample", int'(d), int'(ts[s]));
            rd(s, 15, d);
            check("R6 seg newest", int'(d), int'(8'(ts[s] + 8'd7)));
        end
    endtask

    task automatic t_mask();
        logic [7:0] t, d; int n;
        chan_en = 8'h0F;
        do_arm(2'd0, 2'd0, 2'd0);
        idle(12);
        fire(t);
        wait_done(n);
        rd(0, 8, d);
        check("R7 masked lanes zero", int'(d), int'(t & 8'h0F));
        chan_en = '1;
    endtask

    task automatic t_free();
        logic [7:0] t, v, d;
        do_arm(2'd2, 2'd0, 2'd0);
        idle(10);
        fire(t);
        check("R8 trigger ignored", int'(stat_state), 1);
        idle(90);
        check("R8 still WAIT", int'(stat_state), 1);
        stop_run(v);
        check("R8 halt to DONE", int'(stat_state), 3);
        rd(0, 63, d);
        check("R8 valid", int'(rd_valid_cnt), 64);
        check("R8 trig idx 0", int'(rd_trig_idx), 0);
        check("R8 newest", int'(d), int'(8'(v - 8'd1)));
    endtask

    task automatic t_abort();
        logic [7:0] v;
        do_arm(2'd0, 2'd1, 2'd0);
        idle(4);
        stop_run(v);
        check("R9 halt to IDLE", int'(stat_state), 0);
        fire(v);
        idle(2);
        check("R10 trig in IDLE ignored", int'(stat_state), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_circ_pre();
        t_circ_early();
        t_circ_post();
        t_segmented();
        t_mask();
        t_free();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule